// File: doc/BRIEF.md
# Secondary Bus Request/Grant Arbiter

This block decides which master may use the secondary side of a shared parallel bus behind a bridge. Nine external masters request the bus on active-low lines. The bridge's own master requests through a plain active-high input. The block answers with nine active-low grant lines and one grant flag for the bridge itself. Pending requesters are served in round-robin order. When nobody asks for the bus, ownership parks on the bridge. While the bridge holds an idle bus, a park output tells the datapath to drive the address/data, command/byte-enable and parity lines.

A strap input picks the arbitration mode. With the strap low, the block arbitrates by itself. With the strap high, an outside arbiter takes over. Request line 0 then carries that arbiter's grant to the bridge, and grant line 0 carries the bridge's request out to it. The only bus status the block reads is the pair of FRAME and IRDY idle indications. Grants are single-bit control, so no valid/ready handshake applies.

Top module: `sec_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, every `gnt_n` bit is 1 and `park` and `own_gnt` are 0, starting at once and without waiting for a clock edge.
- R2: In internal mode, at most one of {`own_gnt`, inverted `gnt_n[8:0]`} is asserted in any cycle.
- R3: Once a grant line rises to 1 (deasserted), it stays at 1 for at least 2 clocks before it can fall to 0 again.
- R4: Requesters are indexed 0..8 (`req_n` bits) and 9 (the bridge, `own_req`). When the bus is re-arbitrated, the next owner is the first pending index after the current owner, counting upward and wrapping from 9 to 0.
- R5: The grant moves only when the bus is idle (`frame_n`=1 and `irdy_n`=1) with the owner's grant live, or when the owner has dropped its request. While `frame_n` is 0 and the owner keeps requesting, its grant holds.
- R6: With no request pending and an idle bus, ownership parks on the bridge: `own_gnt`=1 and all `gnt_n` bits are 1.
- R7: `park` is 1 exactly when `own_gnt` is 1 and the bus is idle. It drops in the same cycle that `frame_n` or `irdy_n` goes low.
- R8: In external mode (`ext_mode`=1), `gnt_n[8:1]` stay at 1, `gnt_n[0]` equals the inverse of `own_req`, `own_gnt` equals the inverse of `req_n[0]`, and `req_n[8:1]` have no effect.
- R9: A requester that can be granted at once is granted on the first clock edge after its request, so its `gnt_n` bit is low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary bus clock |
| rst_n | input | 1 | Secondary reset, active low, asynchronous |
| ext_mode | input | 1 | Strap: 0 selects internal arbitration, 1 selects external arbitration |
| frame_n | input | 1 | Bus FRAME, active low |
| irdy_n | input | 1 | Bus IRDY, active low |
| own_req | input | 1 | The bridge's own master has a transaction pending |
| req_n | input | 9 | External requests, active low (in external mode bit 0 is the grant from outside) |
| gnt_n | output | 9 | Grants, active low (in external mode bit 0 is the bridge's request out) |
| own_gnt | output | 1 | The bridge holds the bus |
| park | output | 1 | Drive the address/data, command and parity lines while idle |

## Verification
The assertions assume that the strap stays fixed except while reset is asserted. They also assume that FRAME only goes low on a bus that has a grant. The grant-hold property further assumes that an owner keeps its request asserted for as long as FRAME is low. The stimulus changes `ext_mode` only inside a reset pulse. Its busy phases drive `frame_n` low only while the granted master keeps its request line low. Every input changes one time unit after a rising edge, so each sample point is set by the registered grant state.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic {
    ARB_INTERNAL = 1'b0,
    ARB_EXTERNAL = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
  parameter int N  = 10,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = last;
    for (int off = 1; off <= N; off++) begin
      int j;
      j = int'(last) + off;
      if (j >= N) j = j - N;
      if (!found && pend[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/sba_gap_guard.sv
module sba_gap_guard #(
  parameter int MIN_GAP = 2,
  localparam int CW  = (MIN_GAP > 1) ? $clog2(MIN_GAP) : 1,
  localparam int LIM = (MIN_GAP > 0) ? MIN_GAP - 1 : 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  output logic gnt
);
  logic [CW-1:0] off_cnt;
  logic          gnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cnt <= CW'(LIM);
      gnt_q   <= 1'b0;
    end else begin
      if (gnt_q) off_cnt <= '0;
      else if (off_cnt != CW'(LIM)) off_cnt <= off_cnt + 1'b1;
      gnt_q <= want && (gnt_q || off_cnt == CW'(LIM));
    end
  end

  assign gnt = gnt_q;

  generate
    if (MIN_GAP == 2) begin : g_gap_chk
      // R3
      dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gnt_q) |=> !gnt_q);
    end
  endgenerate
endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter #(
  parameter int N_EXT   = 9,
  parameter int MIN_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             own_req,
  input  logic [N_EXT-1:0] req_n,
  output logic [N_EXT-1:0] gnt_n,
  output logic             own_gnt,
  output logic             park
);
  import sba_pkg::*;

  localparam int N_ALL  = N_EXT + 1;
  localparam int IW     = $clog2(N_ALL);
  localparam int BRIDGE = N_EXT;

  arb_mode_e        mode;
  logic [N_ALL-1:0] pend;
  logic [N_ALL-1:0] line;
  logic [IW-1:0]    owner_q, owner_d, pick_idx;
  logic             pick_found, idle, live, rearb;

  assign mode = arb_mode_e'(ext_mode);
  assign pend = {own_req, ~req_n};
  assign idle = frame_n & irdy_n;
  assign live = line[owner_q];
  assign rearb = !pend[owner_q] || (idle && live);

  sba_rr_pick #(.N(N_ALL)) u_pick (
    .pend  (pend),
    .last  (owner_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  always_comb begin
    if (mode == ARB_EXTERNAL) owner_d = IW'(BRIDGE);
    else if (rearb)           owner_d = pick_found ? pick_idx : IW'(BRIDGE);
    else                      owner_d = owner_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= IW'(BRIDGE);
    else        owner_q <= owner_d;
  end

  generate
    for (genvar i = 0; i < N_ALL; i++) begin : g_line
      sba_gap_guard #(.MIN_GAP(MIN_GAP)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (mode == ARB_INTERNAL && owner_d == IW'(i)),
        .gnt   (line[i])
      );
    end
  endgenerate

  always_comb begin
    if (mode == ARB_EXTERNAL) begin
      gnt_n    = '1;
      gnt_n[0] = ~(own_req & rst_n);
      own_gnt  = rst_n & ~req_n[0];
    end else begin
      gnt_n   = ~line[N_EXT-1:0];
      own_gnt = rst_n & line[BRIDGE];
    end
  end

  assign park = own_gnt & idle;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> ((&gnt_n) && !park && !own_gnt));

  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> $onehot0({own_gnt, ~gnt_n}));

  // R8
  ext_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> ((&gnt_n[N_EXT-1:1]) && gnt_n[0] == !own_req && own_gnt == !req_n[0]));

  generate
    for (genvar k = 0; k < N_EXT; k++) begin : g_hold
      // R5
      busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && !frame_n && !gnt_n[k] && !req_n[k]) |=> !gnt_n[k]);
    end
  endgenerate
endmodule

// File: tb/sec_bus_arbiter_test.sv
`timescale 1ns/1ps
module sec_bus_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_mode = 1'b0;
  logic       frame_n = 1'b1;
  logic       irdy_n = 1'b1;
  logic       own_req = 1'b0;
  logic [8:0] req_n = 9'h1FF;
  logic [8:0] gnt_n;
  logic       own_gnt, park;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sec_bus_arbiter uut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .frame_n(frame_n),
    .irdy_n(irdy_n), .own_req(own_req), .req_n(req_n), .gnt_n(gnt_n),
    .own_gnt(own_gnt), .park(park)
  );

  function automatic logic [8:0] gmask(int i);
    return ~(9'h001 << i);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(logic mode);
    rst_n = 1'b0; ext_mode = mode; frame_n = 1'b1; irdy_n = 1'b1;
    own_req = 1'b0; req_n = 9'h1FF;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_n = 9'h1F7;
    #1;
    check("R1 gnt_n in reset", 32'(gnt_n), 32'h1FF);
    check("R1 park in reset", 32'(park), 0);
    check("R1 own_gnt in reset", 32'(own_gnt), 0);
  endtask

  task automatic t_park();
    do_reset(1'b0);
    check("R6 bridge parked", 32'(own_gnt), 1);
    check("R6 no external grant", 32'(gnt_n), 32'h1FF);
    check("R7 park when idle", 32'(park), 1);
    frame_n = 1'b0; #1;
    check("R7 park drops when busy", 32'(park), 0);
    frame_n = 1'b1; irdy_n = 1'b0; #1;
    check("R7 park drops on irdy", 32'(park), 0);
    irdy_n = 1'b1;
  endtask

  task automatic t_hold();
    do_reset(1'b0);
    req_n[3] = 1'b0;
    step();
    check("R9 grant one clock after request", 32'(gnt_n), 32'(gmask(3)));
    check("R2 bridge released", 32'(own_gnt), 0);
    frame_n = 1'b0; req_n[5] = 1'b0;
    for (int c = 0; c < 3; c++) begin
      step();
      check("R5 grant held while busy", 32'(gnt_n), 32'(gmask(3)));
    end
    req_n[3] = 1'b1;
    step();
    check("R5 moves when owner drops", 32'(gnt_n), 32'(gmask(5)));
    rst_n = 1'b0; #1;
    check("R1 async reset clears grant", 32'(gnt_n), 32'h1FF);
    check("R1 async reset clears park", 32'(park), 0);
  endtask

  task automatic t_dead();
    do_reset(1'b0);
    req_n[2] = 1'b0; req_n[4] = 1'b0;
    step();
    check("R4 first pending after bridge", 32'(gnt_n), 32'(gmask(2)));
    step();
    check("R4 rotate to next", 32'(gnt_n), 32'(gmask(4)));
    step();
    check("R3 dead time holds line 2 off", 32'(gnt_n), 32'h1FF);
    step();
    check("R3 line 2 regranted after gap", 32'(gnt_n), 32'(gmask(2)));
  endtask

  task automatic t_wrap();
    do_reset(1'b0);
    own_req = 1'b1; req_n[0] = 1'b0; req_n[8] = 1'b0;
    step();
    check("R4 wrap from bridge to 0", 32'(gnt_n), 32'(gmask(0)));
    step();
    check("R4 skip to 8", 32'(gnt_n), 32'(gmask(8)));
    step();
    check("R4 bridge after 8", 32'({own_gnt, gnt_n}), 32'h3FF);
    step();
    check("R4 back to 0", 32'({own_gnt, gnt_n}), 32'(gmask(0)));
  endtask

  task automatic t_ext();
    do_reset(1'b1);
    check("R8 no request out", 32'(gnt_n), 32'h1FF);
    own_req = 1'b1; #1;
    check("R8 request out on grant 0", 32'(gnt_n), 32'h1FE);
    req_n[0] = 1'b0; #1;
    check("R8 outside grant seen", 32'(own_gnt), 1);
    check("R7 park in external mode", 32'(park), 1);
    req_n[5] = 1'b0;
    step(); step();
    check("R8 request 5 ignored", 32'(gnt_n), 32'h1FE);
    frame_n = 1'b0; #1;
    check("R7 park drops busy external", 32'(park), 0);
    rst_n = 1'b0; ext_mode = 1'b0; #1;
  endtask

  initial begin
    t_reset();
    t_park();
    t_hold();
    t_dead();
    t_wrap();
    t_ext();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(1_000_000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule